// File: doc/BRIEF.md
# Bus-Cycle Fault Register

This block holds a 16-bit processor fault word. Error strobes that travel with a bus transfer are captured when that transfer finishes. The capture point is the first clock edge at which the bus-busy line is seen low after it was high. At that edge the error inputs and the cycle attributes are sampled. One error strobe can land in different bits. The choice depends on who owned the cycle (the CPU or another master) and on whether the cycle went to memory or to I/O.

Two system-fault pins are asynchronous to the clock. Each one passes through a synchronizer chain and a rising-edge detector, and a detected edge sets its bits. The bus cycle has no part in that path. Every bit is sticky. Software reads the word on a plain read port and clears chosen bits by writing ones to them. A fault that arrives in the same cycle as a clear of its bit keeps the bit set.

Top module: `fault_capture_reg`

## Requirements
- R1: After reset the register reads 16'h0000.
- R2: A low protect strobe at the end of a bus cycle sets bit 0 when cyc_cpu=1 and bit 1 when cyc_cpu=0.
- R3: A low parity strobe at the end of a bus cycle sets bit 2.
- R4: A low address strobe at the end of a bus cycle sets bit 5 when cyc_io=0 (memory) and bit 8 when cyc_io=1 (I/O).
- R5: Error strobes change nothing unless bus_busy was high on the previous edge and is low on the sampling edge. Strobes pulsed while the bus is busy or idle are ignored.
- R6: The three bus error strobes are active low. A high level sets nothing.
- R7: A rising edge on sys_fault0 sets bit 7, visible after the (SYNC_STAGES+1)th rising clock edge. A level that stays high does not set the bit again after it has been cleared.
- R8: A rising edge on sys_fault1 sets bits 13 and 15 together, with the same latency as R7.
- R9: Set bits hold until a write with wr_en=1 carries a one in their position. Positions written with zero are unchanged.
- R10: When a new fault and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: Bits 3, 4, 6, 9-12 and 14 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_busy | input | 1 | High while a bus transfer is in progress |
| cyc_cpu | input | 1 | 1 = current cycle is owned by the CPU |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| prot_err_n | input | 1 | Memory protect error strobe, active low |
| par_err_n | input | 1 | Memory parity error strobe, active low |
| addr_err_n | input | 1 | External address error strobe, active low |
| sys_fault0 | input | 1 | Asynchronous system fault 0, rising-edge sensitive |
| sys_fault1 | input | 1 | Asynchronous system fault 1, rising-edge sensitive |
| wr_en | input | 1 | Clear-write strobe |
| wr_data | input | WIDTH | Clear mask; ones clear bits |
| rd_data | output | WIDTH | Current fault word |

## Verification
A wrong internal state shows up on rd_data in the cycle after the edge that caused it. There are three ways it can happen. A stale bus-busy history would set bits on an edge that is not a cycle end. A wrong ownership or cycle-type route would light the neighbouring bit. A broken edge detector would set the system-fault bits a cycle early or late, or set them again while the pin stays high. The bench sweeps every combination of ownership, cycle type and the three strobes. It checks the exact word one cycle after each cycle end, and it checks the system-fault bits on both sides of the expected edge.

// File: rtl/fault_pkg.sv
package fault_pkg;
   localparam int FB_PROT_CPU  = 0;
   localparam int FB_PROT_EXT  = 1;
   localparam int FB_PARITY    = 2;
   localparam int FB_ADDR_MEM  = 5;
   localparam int FB_SYS0      = 7;
   localparam int FB_ADDR_IO   = 8;
   localparam int FB_SYS1_A    = 13;
   localparam int FB_SYS1_B    = 15;
   localparam int FB_MIN_WIDTH = 16;

   function automatic logic [FB_MIN_WIDTH-1:0] live_bits();
      logic [FB_MIN_WIDTH-1:0] m;
      m = '0;
      m[FB_PROT_CPU] = 1'b1;
      m[FB_PROT_EXT] = 1'b1;
      m[FB_PARITY]   = 1'b1;
      m[FB_ADDR_MEM] = 1'b1;
      m[FB_SYS0]     = 1'b1;
      m[FB_ADDR_IO]  = 1'b1;
      m[FB_SYS1_A]   = 1'b1;
      m[FB_SYS1_B]   = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/fr_sync_edge.sv
module fr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fr_bus_sample.sv
module fr_bus_sample
   import fault_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_busy,
   input  logic             cyc_cpu,
   input  logic             cyc_io,
   input  logic             prot_err_n,
   input  logic             par_err_n,
   input  logic             addr_err_n,
   output logic [WIDTH-1:0] set_mask
);
   logic busy_q;
   logic cyc_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= bus_busy;
   end

   assign cyc_end = busy_q & ~bus_busy;

   always_comb begin
      set_mask = '0;
      if (cyc_end) begin
         set_mask[FB_PROT_CPU] = ~prot_err_n &  cyc_cpu;
         set_mask[FB_PROT_EXT] = ~prot_err_n & ~cyc_cpu;
         set_mask[FB_PARITY]   = ~par_err_n;
         set_mask[FB_ADDR_MEM] = ~addr_err_n & ~cyc_io;
         set_mask[FB_ADDR_IO]  = ~addr_err_n &  cyc_io;
      end
   end
endmodule

// File: rtl/fr_sticky_reg.sv
module fr_sticky_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           q[i] <= 1'b0;
         else if (set_mask[i]) q[i] <= 1'b1;
         else if (clr_mask[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/fault_capture_reg.sv
module fault_capture_reg
   import fault_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_busy,
   input  logic             cyc_cpu,
   input  logic             cyc_io,
   input  logic             prot_err_n,
   input  logic             par_err_n,
   input  logic             addr_err_n,
   input  logic             sys_fault0,
   input  logic             sys_fault1,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data
);
   initial begin
      if (WIDTH < FB_MIN_WIDTH) $fatal(1, "WIDTH must be at least 16");
      if (SYNC_STAGES < 2)      $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] bus_set;
   logic [WIDTH-1:0] sys_set;
   logic [WIDTH-1:0] clr_mask;
   logic             rise0;
   logic             rise1;

   fr_bus_sample #(.WIDTH(WIDTH)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_busy   (bus_busy),
      .cyc_cpu    (cyc_cpu),
      .cyc_io     (cyc_io),
      .prot_err_n (prot_err_n),
      .par_err_n  (par_err_n),
      .addr_err_n (addr_err_n),
      .set_mask   (bus_set)
   );

   fr_sync_edge #(.STAGES(SYNC_STAGES)) u_sf0 (
      .clk (clk), .rst_n (rst_n), .async_in (sys_fault0), .rise (rise0)
   );

   fr_sync_edge #(.STAGES(SYNC_STAGES)) u_sf1 (
      .clk (clk), .rst_n (rst_n), .async_in (sys_fault1), .rise (rise1)
   );

   always_comb begin
      sys_set            = '0;
      sys_set[FB_SYS0]   = rise0;
      sys_set[FB_SYS1_A] = rise1;
      sys_set[FB_SYS1_B] = rise1;
   end

   assign clr_mask = wr_en ? wr_data : '0;

   fr_sticky_reg #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (bus_set | sys_set),
      .clr_mask (clr_mask),
      .q        (rd_data)
   );
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk
   import fault_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_busy,
   input logic             cyc_cpu,
   input logic             cyc_io,
   input logic             prot_err_n,
   input logic             par_err_n,
   input logic             addr_err_n,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] live;
   assign live = WIDTH'(live_bits());

   // R9
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

   // R11
   dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~live) == '0);

   // R2
   prot_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_PROT_CPU]) |->
         ($past(bus_busy, 2) && !$past(bus_busy) && $past(cyc_cpu) && !$past(prot_err_n)));

   // R2
   prot_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_PROT_EXT]) |->
         ($past(bus_busy, 2) && !$past(bus_busy) && !$past(cyc_cpu) && !$past(prot_err_n)));

   // R3
   parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_PARITY]) |->
         ($past(bus_busy, 2) && !$past(bus_busy) && !$past(par_err_n)));

   // R4
   addr_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_ADDR_MEM]) |->
         ($past(bus_busy, 2) && !$past(bus_busy) && !$past(cyc_io) && !$past(addr_err_n)));

   // R4
   addr_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_ADDR_IO]) |->
         ($past(bus_busy, 2) && !$past(bus_busy) && $past(cyc_io) && !$past(addr_err_n)));

   // R8
   sys1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[FB_SYS1_A]) |-> rd_data[FB_SYS1_B]);

   // R9
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_busy) |=> ((rd_data & $past(wr_data) & ~WIDTH'(1 << FB_SYS0)
                                & ~WIDTH'(1 << FB_SYS1_A) & ~WIDTH'(1 << FB_SYS1_B)) == '0));
endmodule

bind fault_capture_reg fault_capture_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_busy   (bus_busy),
   .cyc_cpu    (cyc_cpu),
   .cyc_io     (cyc_io),
   .prot_err_n (prot_err_n),
   .par_err_n  (par_err_n),
   .addr_err_n (addr_err_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data)
);

// File: tb/tb_fault_capture_reg.sv
module tb_fault_capture_reg;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_busy = 1'b0, cyc_cpu = 1'b0, cyc_io = 1'b0;
   logic         prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
   logic         sys_fault0 = 1'b0, sys_fault1 = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   fault_capture_reg #(.WIDTH(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .cyc_cpu(cyc_cpu),
      .cyc_io(cyc_io), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
      .addr_err_n(addr_err_n), .sys_fault0(sys_fault0), .sys_fault1(sys_fault1),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [W-1:0] exp);
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
      end
   endtask

   task automatic clear(input logic [W-1:0] m);
      @(negedge clk); wr_en = 1'b1; wr_data = m;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   // busy for one cycle, strobes driven while bus_busy is low on the sampling edge
   task automatic bus_cycle(input bit cpu, input bit io, input bit pn, input bit rn, input bit an);
      @(negedge clk); bus_busy = 1'b1; cyc_cpu = cpu; cyc_io = io;
      @(negedge clk); bus_busy = 1'b0; prot_err_n = pn; par_err_n = rn; addr_err_n = an;
      @(negedge clk); prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
   endtask

   function automatic logic [W-1:0] expect_word(bit cpu, bit io, bit pn, bit rn, bit an);
      logic [W-1:0] e = '0;
      if (!pn) e = e | (cpu ? W'(1) : W'(2));
      if (!rn) e = e | W'(4);
      if (!an) e = e | (io ? W'(16'h0100) : W'(16'h0020));
      return e;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 16'h0000);

      // R2 R3 R4 R6: full sweep of ownership, cycle type and strobe levels
      for (int v = 0; v < 32; v++) begin
         bit cpu = v[4], io = v[3], pn = v[2], rn = v[1], an = v[0];
         bus_cycle(cpu, io, pn, rn, an);
         check($sformatf("R2/R3/R4/R6 sweep cpu=%0d io=%0d p=%0d r=%0d a=%0d", cpu, io, pn, rn, an),
               expect_word(cpu, io, pn, rn, an));
         clear('1);
         check("R9 clear all", 16'h0000);
      end

      // R5: strobes while busy without a cycle end
      @(negedge clk); bus_busy = 1'b1; cyc_cpu = 1'b1;
      @(negedge clk); prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
      repeat (2) @(negedge clk);
      prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
      @(negedge clk);
      check("R5 strobes during busy", 16'h0000);
      bus_busy = 1'b0;
      @(negedge clk);
      check("R5 cycle end with strobes idle", 16'h0000);
      // R5: strobes while idle
      prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
      repeat (3) @(negedge clk);
      prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
      @(negedge clk);
      check("R5 strobes while idle", 16'h0000);

      // R7: system fault 0 latency and edge-only behaviour
      sys_fault0 = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 not yet after two edges", 16'h0000);
      @(negedge clk);
      check("R7 set after third edge", 16'h0080);
      clear(16'h0080);
      repeat (4) @(negedge clk);
      check("R7 level held does not re-set", 16'h0000);
      sys_fault0 = 1'b0;
      repeat (4) @(negedge clk);

      // R8: system fault 1 sets the pair
      sys_fault1 = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 not yet after two edges", 16'h0000);
      @(negedge clk);
      check("R8 pair set", 16'hA000);
      sys_fault1 = 1'b0;

      // R9: partial clear keeps the rest
      bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R9 accumulate", 16'hA106);
      clear(16'h2004);
      check("R9 partial clear", 16'h8102);
      repeat (3) @(negedge clk);
      check("R9 sticky hold", 16'h8102);
      clear('1);

      // R10: set and clear of bit 0 in the same cycle
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      check("R10 setup", 16'h0001);
      @(negedge clk); bus_busy = 1'b1; cyc_cpu = 1'b1;
      @(negedge clk); bus_busy = 1'b0; prot_err_n = 1'b0; wr_en = 1'b1; wr_data = 16'h0001;
      @(negedge clk); prot_err_n = 1'b1; wr_en = 1'b0; wr_data = '0;
      check("R10 set wins over clear", 16'h0001);

      // R11: writing ones to unused bits leaves them zero
      clear('1);
      check("R11 unused bits zero", 16'h0000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule